// File: doc/BRIEF.md
# Serial-Loaded Three-Row LED Dial Scanner

This block drives a dial of LEDs arranged as three common-cathode rows of twelve anodes each. A host loads a 24-bit word bit by bit on a slow data/clock pair. It then raises a separate commit strobe that moves the loaded word into a display register. The host only needs to send data when the picture should change. Between updates the block refreshes the dial on its own.

A free-running scan enables one row at a time. Each row stays enabled for a fixed number of system clocks. While a row is enabled, its 8-bit index selects one of the twelve anode lines. An index of twelve or more leaves every anode dark, but that row still keeps its time slot in the scan. All anodes are held dark for one system clock after each row change, so that the previous row's pattern does not bleed into the next row.

The three host inputs are asynchronous to the system clock. They are synchronised and edge-detected inside the block.

Top module: `dial_scan_driver`

## Requirements
- R1: After reset, the display register holds 0xFF in every row field, the row enable equals 3'b001, and every anode output is 0.
- R2: On each rising edge of the shift clock, the data bit is taken into the top of a 24-bit shift register and the older bits move down. After any number of bits, only the 24 most recent are kept. The first of these lands in bit 0 and the last in bit 23. Row 0 reads bits [7:0], row 1 reads bits [15:8] and row 2 reads bits [23:16].
- R3: Shifting bits without a rising edge on the commit input leaves the anode pattern of every row unchanged.
- R4: A rising edge on the commit input copies the shift register into the display register. When the shift clock and the commit input rise together, the display register receives the shift contents from before that same edge.
- R5: In a row's slot, except in its first cycle, an index of 0 to 11 drives exactly anode_o[index] high and all other anodes low.
- R6: An index of 12 to 255 drives all twelve anodes low, and the row is still enabled for its full slot.
- R7: Exactly one row enable is high at any time. The rows advance in the order 0, 1, 2, 0, each for DWELL system clocks.
- R8: In the first system clock after the row enable changes, all anodes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_data_i | input | 1 | Serial data bit, asynchronous |
| ser_clk_i | input | 1 | Shift clock; the rising edge takes a bit, asynchronous |
| latch_i | input | 1 | Commit strobe; the rising edge loads the display register, asynchronous |
| row_en_o | output | 3 | One-hot common-cathode row enable |
| anode_o | output | 12 | One-hot anode select for the enabled row |

## Verification
The assertions assume the following about the host inputs:
- Each high or low phase of the shift clock and the commit strobe lasts longer than the synchroniser delay, so every edge is seen exactly once.
- The data bit is stable for a few system clocks on both sides of each shift-clock rise.

The stimulus holds every serial level for at least three system clocks. It changes the data bit only while the shift clock is low and well before the clock rises. Under these conditions, the display-register checks can compare against the shift contents from one clock earlier.

// File: rtl/dial_pkg.sv
package dial_pkg;
  localparam int IDX_W = 8;
  localparam int LED_N = 12;

  // Index to one-hot anode select; codes past the last LED give all zero.
  function automatic logic [LED_N-1:0] led_select(input logic [IDX_W-1:0] idx);
    logic [LED_N-1:0] sel;
    sel = '0;
    for (int i = 0; i < LED_N; i++) begin
      if (idx == IDX_W'(i)) sel[i] = 1'b1;
    end
    return sel;
  endfunction

  // Next row number with wrap.
  function automatic int unsigned next_row(input int unsigned r, input int unsigned rows);
    return (r + 1 >= rows) ? 0 : r + 1;
  endfunction
endpackage

// File: rtl/dial_sync.sv
module dial_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/dial_shift_store.sv
module dial_shift_store #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_lvl,
  input  logic              sclk_lvl,
  input  logic              latch_lvl,
  output logic              shift_pulse,
  output logic              commit_pulse,
  output logic [WORD_W-1:0] shift_word,
  output logic [WORD_W-1:0] store_word
);
  logic sclk_q, latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_lvl;
      latch_q <= latch_lvl;
    end
  end

  assign shift_pulse  = sclk_lvl & ~sclk_q;
  assign commit_pulse = latch_lvl & ~latch_q;

  // Newest bit enters at the top; after WORD_W shifts the first bit sits in bit 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_word <= '1;
    end else if (shift_pulse) begin
      shift_word <= {data_lvl, shift_word[WORD_W-1:1]};
    end
  end

  // Takes the pre-shift value when both edges coincide.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_word <= '1;
    end else if (commit_pulse) begin
      store_word <= shift_word;
    end
  end
endmodule

// File: rtl/dial_row_scan.sv
module dial_row_scan #(
  parameter int ROWS  = 3,
  parameter int DWELL = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [$clog2(ROWS)-1:0] row_idx,
  output logic                    row_step,
  output logic                    guard
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;

  logic [CNT_W-1:0] cnt;

  assign row_step = (cnt == CNT_W'(DWELL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      row_idx <= '0;
      guard   <= 1'b1;
    end else begin
      cnt   <= row_step ? '0 : cnt + 1'b1;
      guard <= row_step;
      if (row_step)
        row_idx <= ROW_W'(dial_pkg::next_row(int'(row_idx), ROWS));
    end
  end
endmodule

// File: rtl/dial_scan_driver.sv
module dial_scan_driver #(
  parameter int ROWS        = 3,
  parameter int DWELL       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_data_i,
  input  logic            ser_clk_i,
  input  logic            latch_i,
  output logic [ROWS-1:0] row_en_o,
  output logic [11:0]     anode_o
);
  import dial_pkg::*;

  localparam int WORD_W = ROWS * IDX_W;
  localparam int ROW_W  = $clog2(ROWS);

  logic [2:0]        lvl;
  logic              shift_pulse, commit_pulse;
  logic [WORD_W-1:0] shift_word, store_word;
  logic [ROW_W-1:0]  row_idx;
  logic              row_step, guard;
  logic [IDX_W-1:0]  cur_idx;

  dial_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({latch_i, ser_clk_i, ser_data_i}),
    .sync_o  (lvl)
  );

  dial_shift_store #(.WORD_W(WORD_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_lvl     (lvl[0]),
    .sclk_lvl     (lvl[1]),
    .latch_lvl    (lvl[2]),
    .shift_pulse  (shift_pulse),
    .commit_pulse (commit_pulse),
    .shift_word   (shift_word),
    .store_word   (store_word)
  );

  dial_row_scan #(.ROWS(ROWS), .DWELL(DWELL)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_idx  (row_idx),
    .row_step (row_step),
    .guard    (guard)
  );

  assign cur_idx  = store_word[int'(row_idx) * IDX_W +: IDX_W];
  assign row_en_o = ROWS'(1) << row_idx;
  assign anode_o  = guard ? '0 : led_select(cur_idx);
endmodule

// File: rtl/dial_scan_driver_chk.sv
module dial_scan_driver_chk #(
  parameter int ROWS   = 3,
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ROWS-1:0]   row_en_o,
  input logic [11:0]       anode_o,
  input logic              row_step,
  input logic              commit_pulse,
  input logic              shift_pulse,
  input logic [WORD_W-1:0] shift_word,
  input logic [WORD_W-1:0] store_word,
  input logic [7:0]        cur_idx
);
  // R7: one row at a time
  p_one_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_en_o) == 1);

  // R7: rotation order on each step
  p_row_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    row_step |=> row_en_o == {$past(row_en_o[ROWS-2:0]), $past(row_en_o[ROWS-1])});

  // R8: dark cycle after a row change
  p_guard_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_en_o) |-> anode_o == '0);

  // R5: at most one anode
  p_anode_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(anode_o));

  // R6: out-of-range index blanks
  p_range_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx >= 8'd12) |-> anode_o == '0);

  // R3: display register holds without commit
  p_store_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |=> $stable(store_word));

  // R4: commit takes pre-edge shift contents
  p_commit_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> store_word == $past(shift_word));

  // R2: shift register only moves on a shift edge
  p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pulse |=> $stable(shift_word));
endmodule

bind dial_scan_driver dial_scan_driver_chk #(.ROWS(ROWS), .WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .row_en_o     (row_en_o),
  .anode_o      (anode_o),
  .row_step     (row_step),
  .commit_pulse (commit_pulse),
  .shift_pulse  (shift_pulse),
  .shift_word   (shift_word),
  .store_word   (store_word),
  .cur_idx      (cur_idx)
);

// File: tb/dial_scan_driver_tb_top.sv
`timescale 1ns/1ps
module dial_scan_driver_tb_top;
  localparam int ROWS  = 3;
  localparam int DWELL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data_i = 1'b0, ser_clk_i = 1'b0, latch_i = 1'b0;
  logic [ROWS-1:0] row_en_o;
  logic [11:0]     anode_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [23:0] m_sr    = '1;
  logic [23:0] m_store = '1;

  always #4 clk = ~clk;

  dial_scan_driver #(.ROWS(ROWS), .DWELL(DWELL)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_data_i(ser_data_i), .ser_clk_i(ser_clk_i),
    .latch_i(latch_i), .row_en_o(row_en_o), .anode_o(anode_o)
  );

  function automatic logic [11:0] exp_anode(input logic [7:0] idx);
    return (idx < 8'd12) ? (12'd1 << idx) : 12'd0;
  endfunction

  function automatic int row_of(input logic [ROWS-1:0] en);
    for (int i = 0; i < ROWS; i++) if (en[i]) return i;
    return -1;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, input bit tied);
    ser_data_i = b;
    cyc(3);
    ser_clk_i = 1'b1;
    if (tied) latch_i = 1'b1;
    if (tied) m_store = m_sr;
    m_sr = {b, m_sr[23:1]};
    cyc(4);
    ser_clk_i = 1'b0;
    latch_i   = 1'b0;
    cyc(4);
  endtask

  task automatic shift_word(input logic [23:0] w);
    for (int i = 0; i < 24; i++) shift_bit(w[i], 1'b0);
  endtask

  task automatic commit();
    latch_i = 1'b1;
    m_store = m_sr;
    cyc(4);
    latch_i = 1'b0;
    cyc(5);
  endtask

  // Watches two full scans; R8 dark cycle, otherwise R5/R6 decode.
  task automatic check_scan(input string tag);
    logic [ROWS-1:0] prev;
    logic [11:0] exp;
    int bad = 0;
    logic [11:0] bad_act = '0, bad_exp = '0;
    string btag = tag;
    prev = row_en_o;
    for (int c = 0; c < 2 * ROWS * DWELL; c++) begin
      cyc(1);
      if (row_en_o != prev) begin
        exp = '0;
        if (anode_o !== exp && bad == 0) begin bad = 1; bad_act = anode_o; bad_exp = exp; btag = {tag, " R8"}; end
      end else begin
        int r = row_of(row_en_o);
        exp = (r < 0) ? 12'hfff : exp_anode(m_store[r*8 +: 8]);
        if (anode_o !== exp && bad == 0) begin bad = 1; bad_act = anode_o; bad_exp = exp; end
      end
      prev = row_en_o;
    end
    check(btag, {20'd0, bad_act}, {20'd0, bad_exp});
  endtask

  // R7: order and slot length
  task automatic check_dwell();
    logic [ROWS-1:0] prev;
    int len;
    prev = row_en_o;
    while (row_en_o == prev) cyc(1);
    for (int k = 0; k < ROWS; k++) begin
      prev = row_en_o;
      len = 0;
      while (row_en_o == prev) begin cyc(1); len++; end
      check("R7 dwell", len, DWELL);
      check("R7 order", row_of(row_en_o), (row_of(prev) + 1) % ROWS);
    end
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    void'($urandom(32'd1357));
    cyc(5);
    check("R1 row_en during reset", row_en_o, 3'b001);
    rst_n = 1'b1;
    cyc(1);
    check("R1 row_en after reset", row_en_o, 3'b001);
    check("R1 anode after reset", anode_o, 12'd0);
    check_scan("R1 blank display from reset");

    // R2/R5: directed word
    shift_word({8'd11, 8'd5, 8'd0});
    commit();
    check_scan("R5 indices 0 5 11");
    check_dwell();

    // R3: shift without commit
    shift_word({8'd1, 8'd2, 8'd3});
    check_scan("R3 no commit keeps display");

    // R2: more than 24 bits keeps the last 24
    for (int i = 0; i < 30; i++) shift_bit(1'($urandom), 1'b0);
    commit();
    check_scan("R2 30 bits last 24 kept");

    // R6: out-of-range codes
    shift_word({8'd3, 8'd12, 8'd255});
    commit();
    check_scan("R6 codes 12 and 255 blank");
    check_dwell();

    // R4: shift clock and commit tied
    w = {8'd7, 8'd9, 8'd4};
    for (int i = 0; i < 24; i++) shift_bit(w[i], 1'b1);
    cyc(5);
    check_scan("R4 tied clock and commit");
    shift_bit(1'b0, 1'b1);
    cyc(5);
    check_scan("R4 tied one more bit");

    // Random words, indices mostly in range
    for (int k = 0; k < 8; k++) begin
      for (int r = 0; r < 3; r++) w[r*8 +: 8] = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 12);
      shift_word(w);
      commit();
      check_scan("R5 R6 random word");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule